// File: doc/BRIEF.md
# Forward-Only Lifecycle Stage and Anti-Rollback Version Counter

This block holds two pieces of device security state that may only move forward. The first is the lifecycle stage, one of four stages in a fixed order. The second is a firmware version counter that only rises and saturates at its top value. Software or a boot controller asks for a stage change or a counter change. The block accepts the request only if it moves the state forward, and it answers with a one-cycle accept or reject pulse.

The block also screens a candidate firmware version against the recorded counter. An image older than the counter raises a rollback pulse. An image that is equal or newer raises an accept pulse. The counter holds the oldest permitted version, so this check stops older firmware from being installed.

The values are assumed to live in non-volatile storage outside the block. On every reset the block reloads them from the load inputs and never falls back to a built-in start value. Image signature checking is done elsewhere.

Top module: `lcv_guard`

## Requirements
- R1: While `rst` is high at a rising edge, `stage_o` takes `load_stage_i` and `ver_o` takes `load_ver_i`, and all six result flags are low after that edge. The counter never takes a fixed constant on reset.
- R2: Stage codes are 0 Vendor, 1 OEM, 2 Deployed and 3 RMA. A stage request whose target code is greater than `stage_o` is accepted. After the next rising edge `stage_o` equals the target and `stg_ack_o` is high.
- R3: A stage request whose target is equal to or lower than `stage_o` is rejected. After the next edge `stg_nak_o` is high and `stage_o` is unchanged.
- R4: Skipping stages is allowed. For example, a request from Vendor (0) straight to Deployed (2) is accepted.
- R5: A version request with `ver_mode_i`=0 (set) and `ver_new_i` greater than `ver_o` is accepted. After the next edge `ver_o` equals `ver_new_i` and `ver_ack_o` is high.
- R6: A set request with `ver_new_i` not greater than `ver_o` is rejected. After the next edge `ver_nak_o` is high and `ver_o` is unchanged.
- R7: A version request with `ver_mode_i`=1 (step) raises `ver_o` by one and is accepted. When `ver_o` is at its all-ones maximum, a step request is rejected and `ver_o` stays at the maximum.
- R8: A candidate with `cand_ver_i` below `ver_o` gives `rollback_o` high after the next edge. A candidate equal to or above `ver_o` gives `cand_ok_o` high instead. The comparison uses the counter value held before any version change made in the same cycle.
- R9: Each result flag is high for exactly one cycle per request. In a cycle with no request, every flag is low after the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; reloads persisted state |
| load_stage_i | input | 2 | Persisted stage loaded on reset |
| load_ver_i | input | VER_W | Persisted counter value loaded on reset |
| stg_req_i | input | 1 | Stage change request strobe |
| stg_target_i | input | 2 | Requested target stage |
| ver_req_i | input | 1 | Version counter request strobe |
| ver_mode_i | input | 1 | 0 = set to `ver_new_i`, 1 = step by one |
| ver_new_i | input | VER_W | New counter value for a set request |
| cand_valid_i | input | 1 | Candidate version check strobe |
| cand_ver_i | input | VER_W | Candidate firmware version |
| stage_o | output | 2 | Current lifecycle stage |
| ver_o | output | VER_W | Current version counter |
| stg_ack_o | output | 1 | Stage request accepted pulse |
| stg_nak_o | output | 1 | Stage request rejected pulse |
| ver_ack_o | output | 1 | Version request accepted pulse |
| ver_nak_o | output | 1 | Version request rejected pulse |
| cand_ok_o | output | 1 | Candidate version permitted pulse |
| rollback_o | output | 1 | Candidate version older than counter pulse |

## Verification
Every result sits exactly one register stage from its request. The bench drives a strobe on a falling edge and removes it on the next falling edge. At that same falling edge it reads the accept or reject flag together with the updated `stage_o` or `ver_o`. One cycle later it reads all flags again to confirm each pulse has ended. Reset loads are checked at the first falling edge after the reset edge. For same-cycle set and candidate requests, the bench expects the verdict against the old counter value while `ver_o` already shows the new one.

// File: rtl/lcv_pkg.sv
package lcv_pkg;
  localparam int STG_W = 2;

  typedef enum logic [STG_W-1:0] {
    STG_MAKER   = 2'd0,
    STG_INTEG   = 2'd1,
    STG_FIELD   = 2'd2,
    STG_RETURN  = 2'd3
  } stage_e;

  function automatic logic stage_is_later(input stage_e cur, input stage_e tgt);
    return tgt > cur;
  endfunction
endpackage

// File: rtl/lcv_stage_fsm.sv
module lcv_stage_fsm
  import lcv_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [STG_W-1:0] load_stage,
  input  logic             req,
  input  logic [STG_W-1:0] target,
  output stage_e           stage_q,
  output logic             ack_q,
  output logic             nak_q
);
  logic fwd;
  logic live_q;

  always_comb fwd = stage_is_later(stage_q, stage_e'(target));

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= stage_e'(load_stage);
      ack_q   <= 1'b0;
      nak_q   <= 1'b0;
      live_q  <= 1'b0;
    end else begin
      live_q <= 1'b1;
      ack_q  <= 1'b0;
      nak_q  <= 1'b0;
      if (req) begin
        if (fwd) begin
          stage_q <= stage_e'(target);
          ack_q   <= 1'b1;
        end else begin
          nak_q   <= 1'b1;
        end
      end
    end
  end

  // R2
  stage_mono_chk: assert property (@(posedge clk) disable iff (rst)
    live_q |-> stage_q >= $past(stage_q));
  // R3
  stage_nak_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (live_q && nak_q) |-> stage_q == $past(stage_q));
  // R2
  stage_ack_move_chk: assert property (@(posedge clk) disable iff (rst)
    (live_q && ack_q) |-> stage_q > $past(stage_q));
  // R9
  stage_flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ack_q, nak_q}));
endmodule

// File: rtl/lcv_ver_ctr.sv
module lcv_ver_ctr #(
  parameter int VER_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [VER_W-1:0] load_ver,
  input  logic             req,
  input  logic             step,
  input  logic [VER_W-1:0] new_val,
  output logic [VER_W-1:0] ver_q,
  output logic             ack_q,
  output logic             nak_q
);
  localparam logic [VER_W-1:0] VER_MAX = {VER_W{1'b1}};

  logic             at_max;
  logic             grant;
  logic [VER_W-1:0] next_val;
  logic             live_q;

  always_comb begin
    at_max = (ver_q == VER_MAX);
    if (step) begin
      grant    = !at_max;
      next_val = ver_q + VER_W'(1);
    end else begin
      grant    = new_val > ver_q;
      next_val = new_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ver_q  <= load_ver;
      ack_q  <= 1'b0;
      nak_q  <= 1'b0;
      live_q <= 1'b0;
    end else begin
      live_q <= 1'b1;
      ack_q  <= 1'b0;
      nak_q  <= 1'b0;
      if (req) begin
        if (grant) begin
          ver_q <= next_val;
          ack_q <= 1'b1;
        end else begin
          nak_q <= 1'b1;
        end
      end
    end
  end

  // R6
  ver_mono_chk: assert property (@(posedge clk) disable iff (rst)
    live_q |-> ver_q >= $past(ver_q));
  // R5
  ver_ack_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (live_q && ack_q) |-> ver_q > $past(ver_q));
  // R7
  ver_sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (live_q && $past(ver_q) == VER_MAX) |-> ver_q == VER_MAX);
  // R9
  ver_flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ack_q, nak_q}));
endmodule

// File: rtl/lcv_rollback_chk.sv
module lcv_rollback_chk #(
  parameter int VER_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid,
  input  logic [VER_W-1:0] cand,
  input  logic [VER_W-1:0] floor_ver,
  output logic             ok_q,
  output logic             rb_q
);
  logic older;
  logic live_q;

  always_comb older = cand < floor_ver;

  always_ff @(posedge clk) begin
    if (rst) begin
      ok_q   <= 1'b0;
      rb_q   <= 1'b0;
      live_q <= 1'b0;
    end else begin
      live_q <= 1'b1;
      ok_q   <= valid && !older;
      rb_q   <= valid && older;
    end
  end

  // R8
  verdict_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ok_q, rb_q}));
  // R9
  verdict_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    (live_q && (ok_q || rb_q)) |-> $past(valid));
endmodule

// File: rtl/lcv_guard.sv
module lcv_guard #(
  parameter int VER_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       load_stage_i,
  input  logic [VER_W-1:0] load_ver_i,
  input  logic             stg_req_i,
  input  logic [1:0]       stg_target_i,
  input  logic             ver_req_i,
  input  logic             ver_mode_i,
  input  logic [VER_W-1:0] ver_new_i,
  input  logic             cand_valid_i,
  input  logic [VER_W-1:0] cand_ver_i,
  output logic [1:0]       stage_o,
  output logic [VER_W-1:0] ver_o,
  output logic             stg_ack_o,
  output logic             stg_nak_o,
  output logic             ver_ack_o,
  output logic             ver_nak_o,
  output logic             cand_ok_o,
  output logic             rollback_o
);
  import lcv_pkg::*;

  stage_e           stage_w;
  logic [VER_W-1:0] ver_w;

  lcv_stage_fsm u_stage (
    .clk        (clk),
    .rst        (rst),
    .load_stage (load_stage_i),
    .req        (stg_req_i),
    .target     (stg_target_i),
    .stage_q    (stage_w),
    .ack_q      (stg_ack_o),
    .nak_q      (stg_nak_o)
  );

  lcv_ver_ctr #(.VER_W(VER_W)) u_ver (
    .clk      (clk),
    .rst      (rst),
    .load_ver (load_ver_i),
    .req      (ver_req_i),
    .step     (ver_mode_i),
    .new_val  (ver_new_i),
    .ver_q    (ver_w),
    .ack_q    (ver_ack_o),
    .nak_q    (ver_nak_o)
  );

  lcv_rollback_chk #(.VER_W(VER_W)) u_rb (
    .clk       (clk),
    .rst       (rst),
    .valid     (cand_valid_i),
    .cand      (cand_ver_i),
    .floor_ver (ver_w),
    .ok_q      (cand_ok_o),
    .rb_q      (rollback_o)
  );

  assign stage_o = stage_w;
  assign ver_o   = ver_w;
endmodule

// File: tb/lcv_guard_tb.sv
`timescale 1ns/1ps
module lcv_guard_tb_top;
  localparam int VW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    load_stage_i = '0;
  logic [VW-1:0] load_ver_i = '0;
  logic          stg_req_i = 1'b0;
  logic [1:0]    stg_target_i = '0;
  logic          ver_req_i = 1'b0;
  logic          ver_mode_i = 1'b0;
  logic [VW-1:0] ver_new_i = '0;
  logic          cand_valid_i = 1'b0;
  logic [VW-1:0] cand_ver_i = '0;
  logic [1:0]    stage_o;
  logic [VW-1:0] ver_o;
  logic stg_ack_o, stg_nak_o, ver_ack_o, ver_nak_o, cand_ok_o, rollback_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  lcv_guard #(.VER_W(VW)) dut_i (.*);

  // Vector: {req id 4, kind 2, arg 8, flag_a, flag_b, stage 2, ver 8}
  // kind 0 stage, 1 version set, 2 version step, 3 candidate
  localparam int NV = 16;
  localparam logic [25:0] TBL [NV] = '{
    {4'd4, 2'd0, 8'd2,   1'b1, 1'b0, 2'd2, 8'd5},
    {4'd3, 2'd0, 8'd2,   1'b0, 1'b1, 2'd2, 8'd5},
    {4'd3, 2'd0, 8'd1,   1'b0, 1'b1, 2'd2, 8'd5},
    {4'd2, 2'd0, 8'd3,   1'b1, 1'b0, 2'd3, 8'd5},
    {4'd3, 2'd0, 8'd3,   1'b0, 1'b1, 2'd3, 8'd5},
    {4'd5, 2'd1, 8'd9,   1'b1, 1'b0, 2'd3, 8'd9},
    {4'd6, 2'd1, 8'd9,   1'b0, 1'b1, 2'd3, 8'd9},
    {4'd6, 2'd1, 8'd4,   1'b0, 1'b1, 2'd3, 8'd9},
    {4'd7, 2'd2, 8'd0,   1'b1, 1'b0, 2'd3, 8'd10},
    {4'd8, 2'd3, 8'd9,   1'b0, 1'b1, 2'd3, 8'd10},
    {4'd8, 2'd3, 8'd10,  1'b1, 1'b0, 2'd3, 8'd10},
    {4'd8, 2'd3, 8'd200, 1'b1, 1'b0, 2'd3, 8'd10},
    {4'd5, 2'd1, 8'd255, 1'b1, 1'b0, 2'd3, 8'd255},
    {4'd7, 2'd2, 8'd0,   1'b0, 1'b1, 2'd3, 8'd255},
    {4'd6, 2'd1, 8'd255, 1'b0, 1'b1, 2'd3, 8'd255},
    {4'd8, 2'd3, 8'd254, 1'b0, 1'b1, 2'd3, 8'd255}
  };

  function automatic string tag(input logic [3:0] id);
    case (id)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [5:0] all_flags();
    return {stg_ack_o, stg_nak_o, ver_ack_o, ver_nak_o, cand_ok_o, rollback_o};
  endfunction

  task automatic clear_inputs();
    stg_req_i    = 1'b0;
    ver_req_i    = 1'b0;
    cand_valid_i = 1'b0;
  endtask

  task automatic do_reset(input logic [1:0] st, input logic [VW-1:0] v);
    @(negedge clk);
    clear_inputs();
    load_stage_i = st;
    load_ver_i   = v;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1", "reset stage", 32'(stage_o), 32'(st));
    check("R1", "reset ver", 32'(ver_o), 32'(v));
    check("R1", "reset flags", 32'(all_flags()), 32'd0);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R9 watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    do_reset(2'd0, 8'd5);

    for (int i = 0; i < NV; i++) begin
      logic [3:0] id;
      logic [1:0] kind;
      logic [7:0] arg;
      logic       fa, fb;
      logic [1:0] est;
      logic [7:0] ever;
      logic [1:0] got;
      {id, kind, arg, fa, fb, est, ever} = TBL[i];
      case (kind)
        2'd0: begin stg_req_i = 1'b1; stg_target_i = arg[1:0]; end
        2'd1: begin ver_req_i = 1'b1; ver_mode_i = 1'b0; ver_new_i = arg; end
        2'd2: begin ver_req_i = 1'b1; ver_mode_i = 1'b1; end
        default: begin cand_valid_i = 1'b1; cand_ver_i = arg; end
      endcase
      @(negedge clk);
      clear_inputs();
      case (kind)
        2'd0: got = {stg_ack_o, stg_nak_o};
        2'd3: got = {cand_ok_o, rollback_o};
        default: got = {ver_ack_o, ver_nak_o};
      endcase
      check(tag(id), $sformatf("vector %0d flags", i), 32'(got), 32'({fa, fb}));
      check(tag(id), $sformatf("vector %0d stage", i), 32'(stage_o), 32'(est));
      check(tag(id), $sformatf("vector %0d ver", i), 32'(ver_o), 32'(ever));
      @(negedge clk);
      check("R9", $sformatf("vector %0d pulse end", i), 32'(all_flags()), 32'd0);
    end

    // R1: reload of persisted values, never a constant start value
    do_reset(2'd2, 8'd100);

    // R8: candidate judged against pre-update value while set happens
    ver_req_i = 1'b1; ver_mode_i = 1'b0; ver_new_i = 8'd150;
    cand_valid_i = 1'b1; cand_ver_i = 8'd100;
    @(negedge clk);
    clear_inputs();
    check("R8", "same-cycle cand ok", 32'({cand_ok_o, rollback_o}), 32'b10);
    check("R5", "same-cycle set ack", 32'({ver_ack_o, ver_nak_o}), 32'b10);
    check("R5", "same-cycle ver", 32'(ver_o), 32'd150);
    cand_valid_i = 1'b1; cand_ver_i = 8'd120;
    @(negedge clk);
    clear_inputs();
    check("R8", "cand below new floor", 32'({cand_ok_o, rollback_o}), 32'b01);

    // R4: skip Deployed straight from OEM after reload
    do_reset(2'd1, 8'd150);
    stg_req_i = 1'b1; stg_target_i = 2'd3;
    @(negedge clk);
    clear_inputs();
    check("R4", "skip to RMA", 32'(stage_o), 32'd3);

    // R7: step from one below max reaches max, then saturates
    do_reset(2'd0, 8'd254);
    ver_req_i = 1'b1; ver_mode_i = 1'b1;
    @(negedge clk);
    check("R7", "step to max", 32'(ver_o), 32'd255);
    check("R7", "step ack", 32'(ver_ack_o), 32'd1);
    @(negedge clk);
    clear_inputs();
    check("R7", "step at max nak", 32'({ver_ack_o, ver_nak_o}), 32'b01);
    check("R7", "max held", 32'(ver_o), 32'd255);

    // R9: idle cycles leave flags low
    repeat (2) @(negedge clk);
    check("R9", "idle flags", 32'(all_flags()), 32'd0);

    summary();
  end
endmodule